// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises an interrupt request at a fixed, software-chosen interval on a bus I/O module. Software writes an 8-bit control byte holding an enable flag, a time-base select flag and a 3-bit period multiplier. The block counts clock cycles in units of a time step. It raises `irq` at the end of each period and holds it until the interrupt is acknowledged. During the acknowledge cycle it drives the contents of a separate 8-bit vector register.

There are two step sizes. The short step is `STEP_CYC` clock cycles, and the long step is `SLOW_RATIO` times that. With the defaults and a 16 MHz clock, these give 8.192 ms and 131.072 ms. A period lasts (multiplier + 1) steps. Simulation can shrink `STEP_CYC` to a few cycles. Bus arbitration and interrupt-level selection belong to the surrounding logic. The timer does not depend on what the rest of the module is doing.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, `irq` is 0, `ctrl_rdata` is 8'h00, `vec_rdata` is 8'h00, `vec_valid` is 0 and `vec_out` is 8'h00.
- R2: The control byte is laid out as follows: bit 7 is enable, bit 6 is the slow time base, bits 2:0 are the multiplier, and bits 5:3 are unused. A write to it is visible on `ctrl_rdata` after the next edge with bits 7, 6 and 2:0 as written. Bits 5:3 always read as 0.
- R3: Count the clock edge that captures a control write with bit 7 set as edge 0. `irq` first becomes 1 at edge (m+1)·STEP_CYC when bit 6 is 0, or at edge (m+1)·STEP_CYC·SLOW_RATIO when bit 6 is 1, where m is bits 2:0. It then repeats with the same period.
- R4: Any control write restarts the count from zero. A pending request survives the write if bit 7 of the new value is 1.
- R5: While bit 7 of the control register is 0, `irq` stays 0. A write that clears bit 7 drops a pending request at the capturing edge.
- R6: The vector register is readable and writable. A write appears on `vec_rdata` after the capturing edge.
- R7: While `iack` and `irq` are both 1, `vec_valid` is 1 and `vec_out` equals the vector register in the same cycle. At all other times `vec_out` is 8'h00. An `iack` without a pending request changes nothing.
- R8: An acknowledge captured at an edge clears `irq` at that edge. The exception is when a period ends at the same edge: then `irq` stays 1.
- R9: A period that ends while `irq` is already 1 leaves it at 1 and is not remembered. The count runs on, so after an acknowledge the next request comes at the next period boundary in the original phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register read data |
| vec_we | input | 1 | Vector register write strobe |
| vec_wdata | input | 8 | Vector register write data |
| vec_rdata | output | 8 | Vector register read data |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| vec_valid | output | 1 | Vector is being driven for an acknowledge |
| vec_out | output | 8 | Acknowledge vector |

## Verification
A wrong prescaler limit or step counter shows up first as a request edge arriving early or late against the (m+1)·step count. It appears on the first period after a control write, so each table entry measures that exact cycle count. A corrupted pending flag shows in one of two places: a request that fails to survive an expiry or an acknowledge in the same cycle, or one that drops one edge late. The directed cases look at `irq` on the edge after each such event. A counter that restarts on an acknowledge shows up as a wrong offset to the next request, which is measured directly.

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int STEP_CYC   = 131072,
  parameter int SLOW_RATIO = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  output logic [7:0] ctrl_rdata,
  input  logic       vec_we,
  input  logic [7:0] vec_wdata,
  output logic [7:0] vec_rdata,
  input  logic       iack,
  output logic       irq,
  output logic       vec_valid,
  output logic [7:0] vec_out
);
  localparam int SLOW_CYC = STEP_CYC * SLOW_RATIO;
  localparam int PW       = $clog2(SLOW_CYC);
  localparam logic [PW-1:0] FAST_LAST = PW'(STEP_CYC - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_CYC - 1);

  logic          en_q, slow_q, irq_q;
  logic [2:0]    mult_q, step_q;
  logic [PW-1:0] pre_q;
  logic [7:0]    vec_q;

  wire [PW-1:0] pre_last = slow_q ? SLOW_LAST : FAST_LAST;
  wire tick   = en_q && (pre_q == pre_last);
  wire expire = tick && (step_q == mult_q);
  wire ack    = iack && irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      slow_q <= 1'b0;
      mult_q <= '0;
      pre_q  <= '0;
      step_q <= '0;
      irq_q  <= 1'b0;
    end else if (ctrl_we) begin
      en_q   <= ctrl_wdata[7];
      slow_q <= ctrl_wdata[6];
      mult_q <= ctrl_wdata[2:0];
      pre_q  <= '0;
      step_q <= '0;
      irq_q  <= ctrl_wdata[7] && irq_q && !ack;
    end else begin
      if (en_q) begin
        pre_q  <= tick ? '0 : pre_q + 1'b1;
        step_q <= expire ? '0 : (tick ? step_q + 3'd1 : step_q);
      end
      irq_q <= (irq_q && !ack) || expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_we) vec_q <= vec_wdata;
  end

  assign ctrl_rdata = {en_q, slow_q, 3'b000, mult_q};
  assign vec_rdata  = vec_q;
  assign irq        = irq_q;
  assign vec_valid  = ack;
  assign vec_out    = ack ? vec_q : 8'h00;
endmodule

module periodic_irq_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic [7:0] ctrl_rdata,
  input logic       vec_we,
  input logic [7:0] vec_wdata,
  input logic [7:0] vec_rdata,
  input logic       iack,
  input logic       irq,
  input logic       vec_valid,
  input logic [7:0] vec_out
);
  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_rdata == ($past(ctrl_wdata) & 8'hC7));
  a_r3_rise_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ctrl_rdata[7] && !$past(ctrl_we));
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[7] |-> !irq);
  a_r6_vec_write: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> vec_rdata == $past(vec_wdata));
  a_r7_vec_drive: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out == vec_rdata) && iack && irq);
  a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_out == 8'h00);
  a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(iack) || ($past(ctrl_we) && !$past(ctrl_wdata[7])));
endmodule

bind periodic_irq_timer periodic_irq_timer_chk u_chk (.*);

// File: tb/test_periodic_irq_timer.sv
module test_periodic_irq_timer;
  localparam int STEP  = 4;
  localparam int RATIO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, vec_we = 1'b0, iack = 1'b0;
  logic [7:0] ctrl_wdata = '0, vec_wdata = '0;
  logic [7:0] ctrl_rdata, vec_rdata, vec_out;
  logic irq, vec_valid;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  periodic_irq_timer #(.STEP_CYC(STEP), .SLOW_RATIO(RATIO)) i_periodic_irq_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .vec_we(vec_we), .vec_wdata(vec_wdata),
    .vec_rdata(vec_rdata), .iack(iack), .irq(irq), .vec_valid(vec_valid),
    .vec_out(vec_out));

  // {slow, mult}
  localparam logic [3:0] TABLE [8] = '{4'h0, 4'h1, 4'h3, 4'h7, 4'h8, 4'hA, 4'h5, 4'h2};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic do_ack;
    iack = 1'b1; #1;
    chk("R7 vec_valid", vec_valid, 1);
    chk("R7 vec_out", vec_out, vec_rdata);
    @(negedge clk); iack = 1'b0;
  endtask

  initial begin
    int n;
    #20000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 ctrl", ctrl_rdata, 0); chk("R1 vec", vec_rdata, 0);
    chk("R1 vec_valid", vec_valid, 0); chk("R1 vec_out", vec_out, 0);
    rst_n = 1'b1;

    // R6 vector register
    @(negedge clk); vec_we = 1'b1; vec_wdata = 8'hA5;
    @(negedge clk); vec_we = 1'b0;
    chk("R6 vec readback", vec_rdata, 8'hA5);

    // R2 reserved bits
    wr_ctrl(8'h3F);
    chk("R2 ctrl readback", ctrl_rdata, 8'h07);
    repeat (40) @(negedge clk);
    chk("R5 disabled no irq", irq, 0);
    iack = 1'b1; #1;
    chk("R7 ack w/o irq vec_valid", vec_valid, 0);
    chk("R7 ack w/o irq vec_out", vec_out, 0);
    @(negedge clk); iack = 1'b0;
    chk("R7 ack w/o irq no effect", irq, 0);

    // R3 table of periods
    foreach (TABLE[i]) begin
      int exp;
      exp = (int'(TABLE[i][2:0]) + 1) * STEP * (TABLE[i][3] ? RATIO : 1);
      wr_ctrl({1'b1, TABLE[i][3], 3'b000, TABLE[i][2:0]});
      chk("R2 ctrl readback", ctrl_rdata, {1'b1, TABLE[i][3], 3'b000, TABLE[i][2:0]});
      wait_irq(n);
      chk("R3 period", n, exp);
      do_ack();
      chk("R8 ack clears", irq, 0);
    end

    // R4 restart on rewrite
    wr_ctrl(8'h83);
    repeat (10) @(negedge clk);
    wr_ctrl(8'h83);
    wait_irq(n);
    chk("R4 restart period", n, 16);

    // R9 expiry while pending absorbed; phase kept (N=16)
    repeat (18) @(negedge clk);
    chk("R9 irq held", irq, 1);
    do_ack();
    chk("R8 ack clears", irq, 0);
    wait_irq(n);
    chk("R9 next rise phase", n, 13);

    // R8 ack coinciding with expiry (period 4)
    do_ack();
    wr_ctrl(8'h80);
    wait_irq(n);
    chk("R3 period m0", n, 4);
    repeat (3) @(negedge clk);
    iack = 1'b1;
    @(negedge clk); iack = 1'b0;
    chk("R8 ack+expiry keeps irq", irq, 1);
    do_ack();
    chk("R8 ack clears", irq, 0);

    // R5 disabling drops pending request
    wait_irq(n);
    chk("R5 pending before disable", irq, 1);
    wr_ctrl(8'h00);
    chk("R5 disable clears", irq, 0);
    repeat (30) @(negedge clk);
    chk("R5 stays quiet", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule